// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port shared memory and watches the enable and address of each port. When both ports are enabled on the same location it lets one of them proceed. The other port gets an active-low busy flag, and its write strobe is held inactive inside the block so that the losing write never reaches the array. The port that settled on the shared location first is the winner. If both arrive in the same clock cycle, the left port wins. The winner stays fixed for as long as the collision lasts. The decision looks only at enables and addresses, never at read or write.

A mode input picks the role of the busy pins. In master mode the block arbitrates and drives both busy flags. In slave mode it stops arbitrating and turns off its busy drivers. Each busy pin then becomes an external write-inhibit input, so several slices of a wide memory can follow the decision of one master. The whole block runs on one clock. Every output is registered and reflects the inputs sampled at the same rising edge.

Top module: `dpcoll_arbiter`

## Requirements
- R1: In master mode, busy is asserted (low) on a port only when both port enables are low and the two addresses are equal. In every other case both busy outputs are high.
- R2: Suppose one port's enable and address were unchanged since the previous edge and the other port's changed, and this creates a collision. The unchanged port wins, and the other port sees busy low from the edge that samples the collision.
- R3: If both ports changed at the collision edge, or both were unchanged (for example just after reset), the left port wins. The two busy outputs are never low together.
- R4: The write strobes play no part in arbitration. Which side is busy is the same for reads and writes.
- R5: In master mode, a port that shows busy low has its gated write strobe held high (inactive) in that same cycle. A port that is not busy passes its strobe through unchanged.
- R6: The busy output-enable follows the mode input, registered: 1 in master mode and 0 in slave mode. In slave mode both busy outputs read high.
- R7: In slave mode, a busy input at 0 holds that port's gated write strobe high. A busy input at 1 lets the strobe pass, whatever the addresses are.
- R8: A collision ends as soon as the addresses differ or either enable goes high. Both busy outputs are high from the edge that samples this.
- R9: While the collision continues, the winner does not change, even when either side toggles its write strobe.
- R10: During and right after reset, both busy outputs and both gated write strobes are high and the output-enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_sel | input | 1 | 1 = master (arbitrate, drive busy), 0 = slave (busy pins are inhibit inputs) |
| l_en_n | input | 1 | Left port enable, active low |
| l_addr | input | ADDR_W | Left port address |
| l_wr_n | input | 1 | Left port write strobe, active low |
| r_en_n | input | 1 | Right port enable, active low |
| r_addr | input | ADDR_W | Right port address |
| r_wr_n | input | 1 | Right port write strobe, active low |
| l_busy_in_n | input | 1 | Left write-inhibit input in slave mode, active low |
| r_busy_in_n | input | 1 | Right write-inhibit input in slave mode, active low |
| l_busy_out_n | output | 1 | Left busy flag, active low |
| r_busy_out_n | output | 1 | Right busy flag, active low |
| busy_oe | output | 1 | Busy pin drive enable (1 in master mode) |
| l_wr_gated_n | output | 1 | Left write strobe to the array, active low |
| r_wr_gated_n | output | 1 | Right write strobe to the array, active low |

## Verification
The one state bit that matters is the remembered winner. If it is wrong, the busy flag sits on the wrong side, and the gated write of the port that should have won is blocked in the same cycle. The remembered previous address and enable of each port are also state. If they are wrong, the tie-break is misjudged at the first colliding edge, and the error shows on the busy outputs right after that edge. A winner that is not held shows up on the cycle after the stable side toggles its strobe, as a busy flag that swaps sides. Exhaustive input sweeps over a 2-bit address, followed by a long pseudo-random sequence, expose each of these within one cycle of the cause.

// File: rtl/dpcoll_pkg.sv
package dpcoll_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_LEFT  = 2'b01,
    OWN_RIGHT = 2'b10
  } owner_e;
endpackage

// File: rtl/dpcoll_port_track.sv
module dpcoll_port_track #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              changed
);
  logic              prev_en_n;
  logic [ADDR_W-1:0] prev_addr;

  // a port counts as settled when enable and address equal last edge's sample
  assign changed = (en_n != prev_en_n) || (addr != prev_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_en_n <= 1'b1;
      prev_addr <= '0;
    end else begin
      prev_en_n <= en_n;
      prev_addr <= addr;
    end
  end
endmodule

// File: rtl/dpcoll_match.sv
module dpcoll_match #(
  parameter int ADDR_W = 15
) (
  input  logic              l_en_n,
  input  logic              r_en_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              hit
);
  assign hit = !l_en_n && !r_en_n && (l_addr == r_addr);
endmodule

// File: rtl/dpcoll_owner.sv
module dpcoll_owner
  import dpcoll_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   master,
  input  logic   hit,
  input  logic   l_chg,
  input  logic   r_chg,
  output owner_e owner_d,
  output owner_e owner_q
);
  always_comb begin
    owner_d = owner_q;
    if (!master || !hit) begin
      owner_d = OWN_NONE;
    end else if (owner_q == OWN_NONE) begin
      // the settled side wins; a tie (both moved or both settled) goes left
      if (l_chg && !r_chg) owner_d = OWN_RIGHT;
      else                 owner_d = OWN_LEFT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_NONE;
    else     owner_q <= owner_d;
  end

  AST_WINNER_HELD: assert property (@(posedge clk) disable iff (rst)
    (master && hit && owner_q != OWN_NONE) |=> (owner_q == $past(owner_q))) else $error("winner changed mid-collision"); // R9

  AST_OWNER_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(owner_q)) else $error("owner encoding"); // R3
endmodule

// File: rtl/dpcoll_outreg.sv
module dpcoll_outreg
  import dpcoll_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   master,
  input  owner_e owner_d,
  input  logic   l_wr_n,
  input  logic   r_wr_n,
  input  logic   l_busy_in_n,
  input  logic   r_busy_in_n,
  output logic   l_busy_out_n,
  output logic   r_busy_out_n,
  output logic   busy_oe,
  output logic   l_wr_gated_n,
  output logic   r_wr_gated_n
);
  logic l_block, r_block;

  always_comb begin
    if (master) begin
      l_block = (owner_d == OWN_RIGHT);
      r_block = (owner_d == OWN_LEFT);
    end else begin
      l_block = !l_busy_in_n;
      r_block = !r_busy_in_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l_busy_out_n <= 1'b1;
      r_busy_out_n <= 1'b1;
      busy_oe      <= 1'b0;
      l_wr_gated_n <= 1'b1;
      r_wr_gated_n <= 1'b1;
    end else begin
      l_busy_out_n <= !(master && owner_d == OWN_RIGHT);
      r_busy_out_n <= !(master && owner_d == OWN_LEFT);
      busy_oe      <= master;
      l_wr_gated_n <= l_wr_n || l_block;
      r_wr_gated_n <= r_wr_n || r_block;
    end
  end

  AST_GATE_LEFT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_oe && !l_busy_out_n) |-> l_wr_gated_n) else $error("left write leaked"); // R5
  AST_GATE_RIGHT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_oe && !r_busy_out_n) |-> r_wr_gated_n) else $error("right write leaked"); // R5
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_oe |-> (l_busy_out_n && r_busy_out_n)) else $error("busy driven in slave"); // R6
endmodule

// File: rtl/dpcoll_arbiter.sv
module dpcoll_arbiter
  import dpcoll_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_sel,
  input  logic              l_en_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr_n,
  input  logic              r_en_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr_n,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_out_n,
  output logic              r_busy_out_n,
  output logic              busy_oe,
  output logic              l_wr_gated_n,
  output logic              r_wr_gated_n
);
  logic   hit, l_chg, r_chg;
  owner_e owner_d, owner_q;

  dpcoll_port_track #(.ADDR_W(ADDR_W)) u_trk_l (
    .clk(clk), .rst(rst), .en_n(l_en_n), .addr(l_addr), .changed(l_chg));
  dpcoll_port_track #(.ADDR_W(ADDR_W)) u_trk_r (
    .clk(clk), .rst(rst), .en_n(r_en_n), .addr(r_addr), .changed(r_chg));

  dpcoll_match #(.ADDR_W(ADDR_W)) u_match (
    .l_en_n(l_en_n), .r_en_n(r_en_n), .l_addr(l_addr), .r_addr(r_addr), .hit(hit));

  dpcoll_owner u_owner (
    .clk(clk), .rst(rst), .master(master_sel), .hit(hit),
    .l_chg(l_chg), .r_chg(r_chg), .owner_d(owner_d), .owner_q(owner_q));

  dpcoll_outreg u_out (
    .clk(clk), .rst(rst), .master(master_sel), .owner_d(owner_d),
    .l_wr_n(l_wr_n), .r_wr_n(r_wr_n),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_out_n(l_busy_out_n), .r_busy_out_n(r_busy_out_n), .busy_oe(busy_oe),
    .l_wr_gated_n(l_wr_gated_n), .r_wr_gated_n(r_wr_gated_n));

  AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (rst)
    (l_busy_out_n || r_busy_out_n)) else $error("both ports busy"); // R3
  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
    !(master_sel && hit) |=> (l_busy_out_n && r_busy_out_n)) else $error("busy without collision"); // R8
  AST_BUSY_FOLLOWS_OWNER: assert property (@(posedge clk) disable iff (rst)
    (owner_q == OWN_LEFT) |-> (!r_busy_out_n && l_busy_out_n)) else $error("busy side vs owner"); // R2
endmodule

// File: tb/dpcoll_arbiter_tb.sv
module dpcoll_arbiter_tb;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms = 1'b1;
  logic le = 1'b1, re = 1'b1, wl = 1'b1, wr = 1'b1, bl = 1'b1, br = 1'b1;
  logic [AW-1:0] la = '0, ra = '0;
  logic lbo, rbo, oe, lg, rg;

  int vectors = 0;
  int fails = 0;
  int m_owner = 0;          // 0 none, 1 left, 2 right
  logic m_ple = 1'b1, m_pre = 1'b1;
  logic [AW-1:0] m_pla = '0, m_pra = '0;
  int unsigned lcg = 32'h1234_5677;

  always #10 clk = ~clk;

  dpcoll_arbiter #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .master_sel(ms),
    .l_en_n(le), .l_addr(la), .l_wr_n(wl),
    .r_en_n(re), .r_addr(ra), .r_wr_n(wr),
    .l_busy_in_n(bl), .r_busy_in_n(br),
    .l_busy_out_n(lbo), .r_busy_out_n(rbo), .busy_oe(oe),
    .l_wr_gated_n(lg), .r_wr_gated_n(rg));

  task automatic chk(input string tag, input logic got, input logic exp);
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // drive one input vector, clock it, compare against the requirement model
  task automatic apply(input logic m, input logic e1, input logic [AW-1:0] a1, input logic w1,
                       input logic e2, input logic [AW-1:0] a2, input logic w2,
                       input logic b1, input logic b2);
    logic hit, lc, rc, eb_l, eb_r;
    @(negedge clk);
    ms = m; le = e1; la = a1; wl = w1; re = e2; ra = a2; wr = w2; bl = b1; br = b2;
    @(posedge clk);
    #1;
    hit = !e1 && !e2 && (a1 == a2);
    lc = (e1 != m_ple) || (a1 != m_pla);
    rc = (e2 != m_pre) || (a2 != m_pra);
    if (!m || !hit) m_owner = 0;
    else if (m_owner == 0) m_owner = (lc && !rc) ? 2 : 1;
    m_ple = e1; m_pla = a1; m_pre = e2; m_pra = a2;
    eb_l = m ? (m_owner == 2) : !b1;
    eb_r = m ? (m_owner == 1) : !b2;
    vectors++;
    chk("R1/R2 left busy", lbo, !(m && m_owner == 2));
    chk("R1/R3 right busy", rbo, !(m && m_owner == 1));
    chk("R6 busy_oe", oe, m);
    chk(m ? "R5 left gate" : "R7 left gate", lg, w1 | eb_l);
    chk(m ? "R5 right gate" : "R7 right gate", rg, w2 | eb_r);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    chk("R10 reset lbusy", lbo, 1'b1);
    chk("R10 reset rbusy", rbo, 1'b1);
    chk("R10 reset oe", oe, 1'b0);
    chk("R10 reset lgate", lg, 1'b1);
    chk("R10 reset rgate", rg, 1'b1);
    @(negedge clk);
    rst = 1'b0;

    // R2: left settles first, right joins the same address
    apply(1, 0, 2'd1, 1, 1, 2'd0, 1, 1, 1);
    apply(1, 0, 2'd1, 1, 0, 2'd1, 0, 1, 1);
    chk("R2 right loses", rbo, 1'b0);
    chk("R5 right write blocked", rg, 1'b1);
    // R9: toggle strobes, winner stays left
    apply(1, 0, 2'd1, 0, 0, 2'd1, 1, 1, 1);
    chk("R9 held", rbo, 1'b0);
    apply(1, 0, 2'd1, 1, 0, 2'd1, 0, 1, 1);
    chk("R9 held again", lbo, 1'b1);
    // R8: addresses diverge
    apply(1, 0, 2'd1, 1, 0, 2'd2, 1, 1, 1);
    chk("R8 release addr", rbo, 1'b1);
    // R2 reverse: right settled at 2, left moves onto it
    apply(1, 0, 2'd2, 0, 0, 2'd2, 1, 1, 1);
    chk("R2 left loses", lbo, 1'b0);
    chk("R5 left write blocked", lg, 1'b1);
    // R8: enable released
    apply(1, 1, 2'd2, 1, 0, 2'd2, 1, 1, 1);
    chk("R8 release enable", lbo, 1'b1);
    // R3 + R4: simultaneous arrival, reads then writes
    apply(1, 1, 2'd0, 1, 1, 2'd0, 1, 1, 1);
    apply(1, 0, 2'd3, 1, 0, 2'd3, 1, 1, 1);
    chk("R3 tie left wins", rbo, 1'b0);
    apply(1, 1, 2'd0, 1, 1, 2'd0, 1, 1, 1);
    apply(1, 0, 2'd3, 0, 0, 2'd3, 0, 1, 1);
    chk("R4 writes same winner", rbo, 1'b0);
    chk("R4 winner write passes", lg, 1'b0);
    // R7: slave, inhibit inputs
    apply(0, 0, 2'd1, 0, 0, 2'd1, 0, 0, 1);
    chk("R7 left inhibited", lg, 1'b1);
    chk("R7 right passes", rg, 1'b0);
    chk("R6 slave busy high", lbo & rbo, 1'b1);

    // exhaustive sweeps in both modes
    for (int m = 1; m >= 0; m--) begin
      for (int i = 0; i < 1024; i++) begin
        apply(m[0], i[0], i[2:1], i[3], i[4], i[6:5], i[7], i[8], i[9]);
      end
    end
    // pseudo-random walk with narrow addresses to produce long collisions
    for (int k = 0; k < 3000; k++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      apply((lcg[31:28] != 4'd0), lcg[27] & lcg[26], lcg[25:24], lcg[23],
            lcg[22] & lcg[21], lcg[20:19], lcg[18], lcg[17], lcg[16]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule